// File: doc/BRIEF.md
# Interrupt Vector Table with Pending Array

This block holds a small table of interrupt messages for a PCI-style function and turns vector-numbered interrupt requests into memory-write messages. Each configured vector owns a 16-byte table slot with a 64-bit message address split across two words, a 32-bit payload word and a control word whose lowest bit masks the vector. Software reaches the table and a read-only pending array through a dword-only register port that decodes a 4 KB window.

A device raises a request by naming a vector. If the vector is configured, has at least one registered user and is not masked, the block emits one message carrying the table's address and payload. If the vector is masked by its own bit or by the function-wide mask input, the request is recorded as a pending bit instead. Any later table write that leaves the written vector unmasked with its pending bit set clears that bit and sends the held message. Per-vector use counters let the device declare which vectors are in service. Requests naming a vector with no users are discarded.

Messages leave through a valid/ready handshake and are held in a single output register. While a message waits, or while the block is re-examining a freshly written slot, both the register port and the request input stall.

Top module: `msix_vector_unit`

## Requirements
- R1: Slot v occupies byte offsets v*16 to v*16+15. Offset +0 holds address bits 31:0, +4 holds address bits 63:32, +8 holds the payload and +12 holds the control word. Control bit 0 is the vector mask and control bits 31:1 read as zero.
- R2: Only accesses with size code 2 (dword) take effect. A read with size code 0 (byte), 1 (halfword) or 3 returns zero, and a write with any of those codes leaves the table unchanged.
- R3: Only address bits 11:2 are decoded, so the window repeats every 4 KB and the two lowest address bits are ignored.
- R4: Reads of offsets that map to no configured slot and no pending word return zero. Writes to them change nothing.
- R5: The pending array is the read-only dword at offset 0x800. Vector v appears at byte v/8, bit v mod 8 of that region, which is bit v of the dword. Writes to it are ignored.
- R6: A request is discarded, with no message and no pending bit, when its vector is at or above the configured count or when its use count is zero.
- R7: A vector is masked when its control bit 0 is set or the mask-all input is high. An accepted request for a masked vector sets its pending bit and produces no message.
- R8: An accepted request for an unmasked vector produces one message whose address is {high word, low word} and whose payload is the slot's data word.
- R9: After an accepted table write to any word of slot v, if v is unmasked and its pending bit is set, the pending bit is cleared and v's message is emitted.
- R10: A use command increments the named vector's count, saturating at its maximum, and is rejected for vectors at or above the configured count. A decrement at zero is ignored. A decrement that reaches zero clears that vector's pending bit.
- R11: Reset clears all use counts, pending bits and table words, and then sets the mask bit of every configured vector. No message is valid after reset.
- R12: A message stays valid with stable address and payload until taken. While it waits, the request input and the register port report not-ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Register access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 32 | Byte address; bits 11:2 decoded |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 dword |
| acc_wdata | input | 32 | Write data |
| acc_ready | output | 1 | Access accepted this cycle when high with acc_valid |
| rd_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rd_data | output | 32 | Read data |
| mask_all | input | 1 | Function-wide mask |
| irq_valid | input | 1 | Interrupt request |
| irq_vec | input | 5 | Requested vector number |
| irq_ready | output | 1 | Request accepted when high with irq_valid |
| use_inc | input | 1 | Increment use count of use_vec |
| use_dec | input | 1 | Decrement use count of use_vec |
| use_vec | input | 5 | Vector for the use command |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Message taken when high with msg_valid |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message payload |

## Verification
The hardest case to reach is delivery on unmask. The bench must first park a request behind a mask and then remove the mask by a table write. It must also cover the case where a write to a word other than the control word releases a vector whose function-wide mask has dropped. The stimulus builds these sequences in order: it programs a slot, registers a user, raises a request under each kind of mask, and checks the pending dword before and after the releasing write. A decrement is also placed between parking and unmasking, to show that the pending bit vanishes and the unmask then sends nothing. Backpressure is produced by holding the message ready low across a request and checking that both input sides stall.

// File: rtl/msixv_pkg.sv
`timescale 1ns/1ps
package msixv_pkg;
  localparam int MAX_VEC = 32;
  localparam int VEC_W   = 5;
  localparam int WORD_W  = 32;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    W_ADDR_LO = 2'd0,
    W_ADDR_HI = 2'd1,
    W_DATA    = 2'd2,
    W_CTRL    = 2'd3
  } slot_word_e;

  localparam logic [11:0] PEND_BASE = 12'h800;
endpackage

// File: rtl/msixv_table.sv
`timescale 1ns/1ps
module msixv_table
  import msixv_pkg::*;
#(
  parameter int NUM_VEC = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [VEC_W-1:0]     wr_vec,
  input  logic [1:0]           wr_word,
  input  logic [WORD_W-1:0]    wr_data,
  input  logic [VEC_W-1:0]     rd_vec,
  input  logic [1:0]           rd_word,
  output logic [WORD_W-1:0]    rd_data,
  input  logic [VEC_W-1:0]     sel_vec,
  output logic [2*WORD_W-1:0]  sel_addr,
  output logic [WORD_W-1:0]    sel_data,
  output logic [MAX_VEC-1:0]   mask_bits
);
  logic [WORD_W-1:0] lo_q  [MAX_VEC];
  logic [WORD_W-1:0] hi_q  [MAX_VEC];
  logic [WORD_W-1:0] dat_q [MAX_VEC];
  logic [MAX_VEC-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int v = 0; v < MAX_VEC; v++) begin
        lo_q[v]   <= '0;
        hi_q[v]   <= '0;
        dat_q[v]  <= '0;
        mask_q[v] <= (v < NUM_VEC);
      end
    end else if (wr_en) begin
      case (wr_word)
        W_ADDR_LO: lo_q[wr_vec]   <= wr_data;
        W_ADDR_HI: hi_q[wr_vec]   <= wr_data;
        W_DATA:    dat_q[wr_vec]  <= wr_data;
        default:   mask_q[wr_vec] <= wr_data[0];
      endcase
    end
  end

  always_comb begin
    case (rd_word)
      W_ADDR_LO: rd_data = lo_q[rd_vec];
      W_ADDR_HI: rd_data = hi_q[rd_vec];
      W_DATA:    rd_data = dat_q[rd_vec];
      default:   rd_data = {{(WORD_W-1){1'b0}}, mask_q[rd_vec]};
    endcase
  end

  assign sel_addr  = {hi_q[sel_vec], lo_q[sel_vec]};
  assign sel_data  = dat_q[sel_vec];
  assign mask_bits = mask_q;
endmodule

// File: rtl/msixv_usecnt.sv
`timescale 1ns/1ps
module msixv_usecnt
  import msixv_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inc,
  input  logic               dec,
  input  logic [VEC_W-1:0]   vec,
  output logic [MAX_VEC-1:0] live,
  output logic [MAX_VEC-1:0] drop_pend
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  for (genvar v = 0; v < MAX_VEC; v++) begin : g_vec
    if (v < NUM_VEC) begin : g_cnt
      logic [CNT_W-1:0] cnt_q;
      logic hit;
      assign hit = (vec == VEC_W'(v));

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q <= '0;
        end else if (hit && inc && !dec && cnt_q != CNT_MAX) begin
          cnt_q <= cnt_q + CNT_ONE;
        end else if (hit && dec && !inc && cnt_q != '0) begin
          cnt_q <= cnt_q - CNT_ONE;
        end
      end

      assign live[v]      = |cnt_q;
      assign drop_pend[v] = hit && dec && !inc && (cnt_q == CNT_ONE);
    end else begin : g_none
      assign live[v]      = 1'b0;
      assign drop_pend[v] = 1'b0;
    end
  end
endmodule

// File: rtl/msixv_deliver.sv
`timescale 1ns/1ps
module msixv_deliver
  import msixv_pkg::*;
#(
  parameter int NUM_VEC = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                irq_valid,
  input  logic [VEC_W-1:0]    irq_vec,
  input  logic                chk_req,
  input  logic [VEC_W-1:0]    chk_vec_in,
  input  logic [MAX_VEC-1:0]  masked,
  input  logic [MAX_VEC-1:0]  live,
  input  logic [MAX_VEC-1:0]  drop_pend,
  output logic [VEC_W-1:0]    sel_vec,
  input  logic [2*WORD_W-1:0] sel_addr,
  input  logic [WORD_W-1:0]   sel_data,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [2*WORD_W-1:0] msg_addr,
  output logic [WORD_W-1:0]   msg_data,
  output logic                idle,
  output logic [MAX_VEC-1:0]  pend
);
  logic                out_q;
  logic [2*WORD_W-1:0] addr_q;
  logic [WORD_W-1:0]   data_q;
  logic                chk_q;
  logic [VEC_W-1:0]    chk_vec_q;
  logic [MAX_VEC-1:0]  pend_q, pend_d;

  logic in_range, irq_take, irq_send, irq_park, chk_fire, chk_send;

  assign idle     = !out_q && !chk_q;
  assign sel_vec  = chk_q ? chk_vec_q : irq_vec;
  assign in_range = ({1'b0, irq_vec} < (VEC_W+1)'(NUM_VEC));
  assign irq_take = irq_valid && idle && in_range && live[irq_vec];
  assign irq_send = irq_take && !masked[irq_vec];
  assign irq_park = irq_take && masked[irq_vec];
  assign chk_fire = chk_q && !out_q;
  assign chk_send = chk_fire && !masked[chk_vec_q] && pend_q[chk_vec_q];

  always_comb begin
    pend_d = pend_q;
    if (irq_park) pend_d[irq_vec] = 1'b1;
    if (chk_send) pend_d[chk_vec_q] = 1'b0;
    pend_d = pend_d & ~drop_pend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q     <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
      chk_q     <= 1'b0;
      chk_vec_q <= '0;
      pend_q    <= '0;
    end else begin
      pend_q <= pend_d;
      if (chk_fire) chk_q <= 1'b0;
      if (chk_req) begin
        chk_q     <= 1'b1;
        chk_vec_q <= chk_vec_in;
      end
      if (out_q && msg_ready) out_q <= 1'b0;
      if (chk_send || irq_send) begin
        out_q  <= 1'b1;
        addr_q <= sel_addr;
        data_q <= sel_data;
      end
    end
  end

  assign msg_valid = out_q;
  assign msg_addr  = addr_q;
  assign msg_data  = data_q;
  assign pend      = pend_q;
endmodule

// File: rtl/msix_vector_unit.sv
`timescale 1ns/1ps
module msix_vector_unit
  import msixv_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int CNT_W   = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [31:0] acc_addr,
  input  logic [1:0]  acc_size,
  input  logic [31:0] acc_wdata,
  output logic        acc_ready,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  input  logic        mask_all,
  input  logic        irq_valid,
  input  logic [4:0]  irq_vec,
  output logic        irq_ready,
  input  logic        use_inc,
  input  logic        use_dec,
  input  logic [4:0]  use_vec,
  output logic        msg_valid,
  input  logic        msg_ready,
  output logic [63:0] msg_addr,
  output logic [31:0] msg_data
);
  logic              unused_addr;
  logic [6:0]        slot_idx;
  logic              is_dword, acc_go, tbl_hit, pend_hit, wr_en;
  logic [VEC_W-1:0]  slot_vec;
  logic [1:0]        slot_word;
  logic [31:0]       tbl_rd;
  logic [VEC_W-1:0]  sel_vec;
  logic [63:0]       sel_addr;
  logic [31:0]       sel_data;
  logic [MAX_VEC-1:0] mask_bits, masked, live, drop_pend, pend;
  logic              idle;
  logic              rd_valid_q;
  logic [31:0]       rd_data_q;

  assign unused_addr = ^{acc_addr[31:12], acc_addr[1:0]};
  assign slot_idx    = acc_addr[10:4];
  assign slot_vec    = acc_addr[8:4];
  assign slot_word   = acc_addr[3:2];
  assign is_dword    = (acc_size == SZ_DWORD);
  assign acc_go      = acc_valid && acc_ready;
  assign tbl_hit     = !acc_addr[11] && (slot_idx < 7'(NUM_VEC));
  assign pend_hit    = (acc_addr[11:2] == PEND_BASE[11:2]);
  assign wr_en       = acc_go && acc_write && is_dword && tbl_hit;
  assign masked      = mask_bits | {MAX_VEC{mask_all}};
  assign acc_ready   = idle;
  assign irq_ready   = idle;

  msixv_table #(.NUM_VEC(NUM_VEC)) u_table (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_vec(slot_vec), .wr_word(slot_word), .wr_data(acc_wdata),
    .rd_vec(slot_vec), .rd_word(slot_word), .rd_data(tbl_rd),
    .sel_vec(sel_vec), .sel_addr(sel_addr), .sel_data(sel_data),
    .mask_bits(mask_bits)
  );

  msixv_usecnt #(.NUM_VEC(NUM_VEC), .CNT_W(CNT_W)) u_usecnt (
    .clk(clk), .rst(rst),
    .inc(use_inc), .dec(use_dec), .vec(use_vec),
    .live(live), .drop_pend(drop_pend)
  );

  msixv_deliver #(.NUM_VEC(NUM_VEC)) u_deliver (
    .clk(clk), .rst(rst),
    .irq_valid(irq_valid), .irq_vec(irq_vec),
    .chk_req(wr_en), .chk_vec_in(slot_vec),
    .masked(masked), .live(live), .drop_pend(drop_pend),
    .sel_vec(sel_vec), .sel_addr(sel_addr), .sel_data(sel_data),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data),
    .idle(idle), .pend(pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= acc_go && !acc_write;
      if (acc_go && !acc_write) begin
        if (!is_dword)     rd_data_q <= '0;
        else if (tbl_hit)  rd_data_q <= tbl_rd;
        else if (pend_hit) rd_data_q <= pend;
        else               rd_data_q <= '0;
      end
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
endmodule

// File: rtl/msixv_checker.sv
`timescale 1ns/1ps
module msixv_checker #(
  parameter int NUM_VEC = 8
) (
  input logic        clk,
  input logic        rst,
  input logic        acc_valid,
  input logic        acc_write,
  input logic [1:0]  acc_size,
  input logic        acc_ready,
  input logic        rd_valid,
  input logic [31:0] rd_data,
  input logic        mask_all,
  input logic        irq_valid,
  input logic [4:0]  irq_vec,
  input logic        irq_ready,
  input logic        msg_valid,
  input logic        msg_ready,
  input logic [63:0] msg_addr,
  input logic [31:0] msg_data
);
  p_narrow_read_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_ready && !acc_write && acc_size != 2'd2) |=> (rd_valid && rd_data == 32'd0));

  p_out_of_range_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && irq_ready && ({1'b0, irq_vec} >= 6'(NUM_VEC))) |=> !msg_valid);

  p_mask_all_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && irq_ready && mask_all) |=> !msg_valid);

  p_msg_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  p_stall_inputs_r12: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (!irq_ready && !acc_ready));
endmodule

bind msix_vector_unit msixv_checker #(.NUM_VEC(NUM_VEC)) u_checker (
  .clk(clk), .rst(rst),
  .acc_valid(acc_valid), .acc_write(acc_write), .acc_size(acc_size),
  .acc_ready(acc_ready), .rd_valid(rd_valid), .rd_data(rd_data),
  .mask_all(mask_all), .irq_valid(irq_valid), .irq_vec(irq_vec),
  .irq_ready(irq_ready), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data)
);

// File: tb/msix_vector_unit_tb.sv
`timescale 1ns/1ps
module msix_vector_unit_tb;
  localparam int NV = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 0, acc_write = 0;
  logic [31:0] acc_addr = '0, acc_wdata = '0;
  logic [1:0]  acc_size = 2'd2;
  logic        acc_ready, rd_valid;
  logic [31:0] rd_data;
  logic        mask_all = 0, irq_valid = 0;
  logic [4:0]  irq_vec = '0;
  logic        irq_ready;
  logic        use_inc = 0, use_dec = 0;
  logic [4:0]  use_vec = '0;
  logic        msg_valid, msg_ready = 1'b1;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  always #2.5 clk = ~clk;

  msix_vector_unit #(.NUM_VEC(NV)) u_dut (
    .clk(clk), .rst(rst),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .acc_size(acc_size), .acc_wdata(acc_wdata), .acc_ready(acc_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .mask_all(mask_all),
    .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_ready(irq_ready),
    .use_inc(use_inc), .use_dec(use_dec), .use_vec(use_vec),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  int n_chk = 0, n_bad = 0, msg_cnt = 0;
  logic [63:0] last_addr = '0;
  logic [31:0] last_data = '0;

  always @(negedge clk) begin
    if (!rst && msg_valid && msg_ready) begin
      msg_cnt++;
      last_addr = msg_addr;
      last_data = msg_data;
    end
  end

  typedef struct packed {
    logic [31:0] wa;
    logic [1:0]  ws;
    logic [31:0] wd;
    logic [31:0] ra;
    logic [31:0] ex;
  } row_t;

  // write address, write size, write data, read address, expected dword
  localparam row_t ROWS [11] = '{
    '{32'h000, 2'd2, 32'hA000_0000, 32'h000, 32'hA000_0000},  // R1 low word
    '{32'h004, 2'd2, 32'h0000_0001, 32'h004, 32'h0000_0001},  // R1 high word
    '{32'h008, 2'd2, 32'h0000_1111, 32'h008, 32'h0000_1111},  // R1 data word
    '{32'h00C, 2'd2, 32'hFFFF_FFFF, 32'h00C, 32'h0000_0001},  // R1 control keeps bit 0 only
    '{32'h010, 2'd0, 32'h0000_0055, 32'h010, 32'h0000_0000},  // R2 byte write ignored
    '{32'h018, 2'd1, 32'h0000_5555, 32'h018, 32'h0000_0000},  // R2 halfword write ignored
    '{32'h01C, 2'd3, 32'h0000_0000, 32'h01C, 32'h0000_0001},  // R2 reserved size ignored
    '{32'h0000_1003, 2'd2, 32'h0000_CAFE, 32'h000, 32'h0000_CAFE}, // R3 wrap and align
    '{32'h100, 2'd2, 32'h0000_1234, 32'h100, 32'h0000_0000},  // R4 slot beyond count
    '{32'h800, 2'd2, 32'h0000_00FF, 32'h800, 32'h0000_0000},  // R5 pending read-only
    '{32'h0A4, 2'd2, 32'h0000_7777, 32'hFA4, 32'h0000_0000}   // R4 unused gap
  };

  task automatic expect_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
    acc_valid = 1; acc_write = 1; acc_addr = a; acc_size = sz; acc_wdata = d;
    while (!acc_ready) @(negedge clk);
    @(posedge clk); #1;
    acc_valid = 0; acc_write = 0;
  endtask

  task automatic bus_rd(input logic [31:0] a, input logic [1:0] sz, output logic [31:0] d);
    acc_valid = 1; acc_write = 0; acc_addr = a; acc_size = sz;
    while (!acc_ready) @(negedge clk);
    @(posedge clk); #1;
    acc_valid = 0;
    d = rd_data;
  endtask

  task automatic irq_req(input logic [4:0] v);
    irq_valid = 1; irq_vec = v;
    while (!irq_ready) @(negedge clk);
    @(posedge clk); #1;
    irq_valid = 0;
  endtask

  task automatic use_op(input logic inc, input logic dec, input logic [4:0] v);
    use_inc = inc; use_dec = dec; use_vec = v;
    @(posedge clk); #1;
    use_inc = 0; use_dec = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] r;
    int base;
    wait_cyc(3);
    rst = 0;
    wait_cyc(1);

    // R11 reset state
    expect_eq("R11 msg_valid after reset", msg_valid, 0);
    expect_eq("R11 irq_ready after reset", irq_ready, 1);
    bus_rd(32'h00C, 2'd2, r); expect_eq("R11 slot0 mask set", r, 1);
    bus_rd(32'h07C, 2'd2, r); expect_eq("R11 slot7 mask set", r, 1);
    bus_rd(32'h030, 2'd2, r); expect_eq("R11 slot3 low zero", r, 0);
    bus_rd(32'h800, 2'd2, r); expect_eq("R11 pending zero", r, 0);

    // table of register vectors: R1 R2 R3 R4 R5
    for (int i = 0; i < 11; i++) begin
      bus_wr(ROWS[i].wa, ROWS[i].ws, ROWS[i].wd);
      bus_rd(ROWS[i].ra, 2'd2, r);
      expect_eq($sformatf("R1/R2/R3/R4/R5 row %0d", i), r, ROWS[i].ex);
    end

    // R2 narrow reads return zero
    bus_rd(32'h000, 2'd0, r); expect_eq("R2 byte read", r, 0);
    bus_rd(32'h000, 2'd1, r); expect_eq("R2 halfword read", r, 0);
    // R4 unimplemented offsets
    bus_rd(32'h804, 2'd2, r); expect_eq("R4 pending+4 read", r, 0);
    bus_rd(32'h400, 2'd2, r); expect_eq("R4 mid-window read", r, 0);

    // R8 plain delivery on vector 2
    bus_wr(32'h020, 2'd2, 32'h1000_0020);
    bus_wr(32'h024, 2'd2, 32'h0000_00AB);
    bus_wr(32'h028, 2'd2, 32'h0000_00D2);
    bus_wr(32'h02C, 2'd2, 32'h0);
    use_op(1, 0, 5'd2);
    base = msg_cnt;
    irq_req(5'd2); wait_cyc(2);
    expect_eq("R8 one message", msg_cnt, base + 1);
    expect_eq("R8 address", last_addr, 64'h0000_00AB_1000_0020);
    expect_eq("R8 payload", last_data, 32'hD2);

    // R6 zero use count and out-of-range vector
    bus_wr(32'h03C, 2'd2, 32'h0);
    base = msg_cnt;
    irq_req(5'd3); wait_cyc(3);
    expect_eq("R6 no message for unused vector", msg_cnt, base);
    bus_rd(32'h800, 2'd2, r); expect_eq("R6 no pending for unused vector", r, 0);
    use_op(1, 0, 5'd9);
    irq_req(5'd9); wait_cyc(3);
    expect_eq("R6 R10 out-of-range vector dropped", msg_cnt, base);

    // R7 own mask parks, R9 unmask delivers
    bus_wr(32'h02C, 2'd2, 32'h1);
    base = msg_cnt;
    irq_req(5'd2); wait_cyc(3);
    expect_eq("R7 masked no message", msg_cnt, base);
    bus_rd(32'h800, 2'd2, r); expect_eq("R7 R5 pending bit 2", r, 32'h4);
    bus_wr(32'h02C, 2'd2, 32'h0); wait_cyc(3);
    expect_eq("R9 unmask sends", msg_cnt, base + 1);
    expect_eq("R9 payload", last_data, 32'hD2);
    bus_rd(32'h800, 2'd2, r); expect_eq("R9 pending cleared", r, 0);

    // R7 mask-all, R9 release through a non-control write
    mask_all = 1;
    base = msg_cnt;
    irq_req(5'd2); wait_cyc(3);
    expect_eq("R7 mask_all no message", msg_cnt, base);
    bus_wr(32'h028, 2'd2, 32'h0000_00E2); wait_cyc(3);
    expect_eq("R9 write under mask_all sends nothing", msg_cnt, base);
    bus_rd(32'h800, 2'd2, r); expect_eq("R7 pending under mask_all", r, 32'h4);
    mask_all = 0;
    bus_wr(32'h020, 2'd2, 32'h1000_0024); wait_cyc(3);
    expect_eq("R9 low-word write releases", msg_cnt, base + 1);
    expect_eq("R9 new address", last_addr, 64'h0000_00AB_1000_0024);
    expect_eq("R9 new payload", last_data, 32'hE2);

    // R10 decrement to zero clears pending
    bus_wr(32'h02C, 2'd2, 32'h1);
    irq_req(5'd2); wait_cyc(2);
    use_op(0, 1, 5'd2); wait_cyc(1);
    bus_rd(32'h800, 2'd2, r); expect_eq("R10 pending cleared on zero count", r, 0);
    base = msg_cnt;
    bus_wr(32'h02C, 2'd2, 32'h0); wait_cyc(3);
    irq_req(5'd2); wait_cyc(3);
    expect_eq("R10 nothing after zero count", msg_cnt, base);

    // R10 counting: two uses, one release, still live
    bus_wr(32'h040, 2'd2, 32'h2000_0040);
    bus_wr(32'h048, 2'd2, 32'h0000_0044);
    bus_wr(32'h04C, 2'd2, 32'h0);
    use_op(1, 0, 5'd4); use_op(1, 0, 5'd4); use_op(0, 1, 5'd4);
    base = msg_cnt;
    irq_req(5'd4); wait_cyc(2);
    expect_eq("R10 count stays live", msg_cnt, base + 1);
    expect_eq("R8 vector4 address", last_addr, 64'h0000_0000_2000_0040);

    // R5 bit position for vector 5
    use_op(1, 0, 5'd5);
    irq_req(5'd5); wait_cyc(2);
    bus_rd(32'h800, 2'd2, r); expect_eq("R5 vector5 bit", r, 32'h20);

    // R12 backpressure
    msg_ready = 0;
    base = msg_cnt;
    irq_req(5'd4); wait_cyc(3);
    expect_eq("R12 msg held valid", msg_valid, 1);
    expect_eq("R12 msg payload held", msg_data, 32'h44);
    expect_eq("R12 irq_ready low", irq_ready, 0);
    expect_eq("R12 acc_ready low", acc_ready, 0);
    msg_ready = 1;
    irq_req(5'd4); wait_cyc(3);
    expect_eq("R12 both delivered", msg_cnt, base + 2);

    // R11 reset in the middle of operation
    rst = 1; wait_cyc(2); rst = 0; wait_cyc(1);
    bus_rd(32'h02C, 2'd2, r); expect_eq("R11 mask restored", r, 1);
    bus_rd(32'h020, 2'd2, r); expect_eq("R11 table zeroed", r, 0);
    bus_rd(32'h800, 2'd2, r); expect_eq("R11 pending cleared", r, 0);
    base = msg_cnt;
    bus_wr(32'h04C, 2'd2, 32'h0);
    irq_req(5'd4); wait_cyc(3);
    expect_eq("R11 use counts cleared", msg_cnt, base);

    summary();
    $finish;
  end
endmodule